// File: doc/BRIEF.md
# Coprocessor Access Control Unit

This block decides, for every coprocessor instruction the pipeline presents, whether the instruction may proceed or must be answered as an undefined instruction. It holds two software-visible registers. The access register carries a 2-bit permission field for each of the fourteen general coprocessors, numbered 0 to 13. The non-secure mask carries one enable bit per coprocessor, and only Secure software may change it. The system-control coprocessor, number 15, has no field. For it the block only checks that the instruction class is one of the two single-register move classes.

A build-time parameter lists the coprocessors that exist. The field of a coprocessor that does not exist holds no storage and always reads back as zero. Software can therefore find out which coprocessors are present by writing all ones to the access register and reading it back. Coprocessors 10 and 11 serve together as one unit, so their two fields are kept equal. The permit/undefined answer is combinational from the request inputs and the stored registers.

Top module: `cp_access_unit`

## Requirements
- R1: After reset, both registers read as zero, and every request for coprocessors 0 to 13 returns undefined.
- R2: In the access register, the field for coprocessor n sits at bits [2n+1:2n]. With the default implemented set {0,1,2,3,10,11}, writing 0x0FFFFFFF reads back 0x00F000FF.
- R3: A field of an unimplemented coprocessor reads 0b00 whatever is written to it, and requests for that coprocessor return undefined.
- R4: Bits 31:28 of the access register read as zero, and writes to them are ignored.
- R5: The fields of coprocessors 10 and 11 always hold the same value. A write to the access register loads both from bits 21:20 of the write data.
- R6: The field codes are: 0b00 denies all access, 0b01 permits privileged access only, 0b10 denies all access, and 0b11 permits privileged and unprivileged access.
- R7: A Non-secure request for coprocessor n (n below 14) is denied when bit n of the non-secure mask is clear, whatever its field holds. Secure requests ignore the mask.
- R8: The non-secure mask takes bits 13:0 of the write data only when the write is marked Secure. A Non-secure write leaves it unchanged. Its bits 31:14 read as zero.
- R9: For coprocessor 15, class code 0 (move to coprocessor) and class code 1 (move from coprocessor) are permitted at any privilege level. Every other 4-bit class code returns undefined.
- R10: Every request for coprocessor 14 returns undefined.
- R11: The decision is combinational from the current register contents. A register write affects requests from the cycle after its clock edge onward.
- R12: When no request is valid, both permit and undefined are low. When a request is valid, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 0 access register, 1 non-secure mask |
| regWrSecure | input | 1 | Write issued from Secure state |
| regWrData | input | 32 | Write data |
| regRdSel | input | 1 | Read target: 0 access register, 1 non-secure mask |
| regRdData | output | 32 | Read data, combinational |
| reqValid | input | 1 | Instruction request valid |
| reqCpNum | input | 4 | Coprocessor number 0 to 15 |
| reqClass | input | 4 | Instruction class code |
| reqPriv | input | 1 | Request made at privileged level |
| reqNonSecure | input | 1 | Request made in Non-secure state |
| reqPermit | output | 1 | Instruction may proceed |
| reqUndef | output | 1 | Instruction is undefined |

## Verification
The assertions check five properties on every cycle. The coprocessor 10 and 11 fields stay equal. Permit and undefined are exclusive, and both are low when no request is valid. An unprivileged permit only ever comes from a full-access field. The mask denial for Non-secure requests holds. Coprocessor 14 and the barred coprocessor 15 classes never pass.

Some behaviours only the bench scenarios can show. The probe readback pattern depends on the implemented set. A Non-secure mask write must be dropped. A write must take effect exactly one cycle later. Each of the four field codes must produce the right answer.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;
  localparam int NUM_CP  = 14;
  localparam int FIELD_W = 2;
  localparam int DATA_W  = 32;
  localparam int CP_W    = 4;
  localparam int FIELDS_W = NUM_CP * FIELD_W;
  localparam int RSVD_W   = DATA_W - FIELDS_W;

  localparam int PAIR_LO = 10;
  localparam int PAIR_HI = 11;
  localparam logic [CP_W-1:0] DEBUG_CP  = 4'd14;
  localparam logic [CP_W-1:0] SYSCTL_CP = 4'd15;

  localparam logic [3:0] CLS_MOVE_TO   = 4'd0;
  localparam logic [3:0] CLS_MOVE_FROM = 4'd1;

  typedef enum logic [FIELD_W-1:0] {
    ACC_NONE = 2'b00,
    ACC_PRIV = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_FULL = 2'b11
  } accField_e;

  typedef struct packed {
    logic accWr;
    logic maskWr;
  } regStrobe_t;
endpackage

// File: rtl/cpacc_datapath.sv
module cpacc_datapath
  import cpacc_pkg::*;
#(
  parameter logic [NUM_CP-1:0] IMPL_MASK = 14'h0C0F
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  regStrobe_t                       strobe,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             rdSel,
  output logic [DATA_W-1:0]                rdData,
  output logic [NUM_CP-1:0][FIELD_W-1:0]   fieldQ,
  output logic [NUM_CP-1:0]                nsMask
);
  logic unusedWr;
  assign unusedWr = ^wrData;

  for (genvar g = 0; g < NUM_CP; g++) begin : gField
    localparam int SRC = (g == PAIR_HI) ? PAIR_LO : g;
    if (IMPL_MASK[g]) begin : gImpl
      logic [FIELD_W-1:0] fieldReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          fieldReg <= ACC_NONE;
        else if (strobe.accWr)
          fieldReg <= wrData[SRC*FIELD_W +: FIELD_W];
      end
      assign fieldQ[g] = fieldReg;
    end else begin : gAbsent
      assign fieldQ[g] = ACC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      nsMask <= '0;
    else if (strobe.maskWr)
      nsMask <= wrData[NUM_CP-1:0];
  end

  always_comb begin
    if (rdSel)
      rdData = {{(DATA_W-NUM_CP){1'b0}}, nsMask};
    else
      rdData = {{RSVD_W{1'b0}}, fieldQ};
  end

  assert_pair_equal_R5: assert property (@(posedge clk) disable iff (!rstN)
    fieldQ[PAIR_LO] == fieldQ[PAIR_HI]);
endmodule

// File: rtl/cpacc_control.sv
module cpacc_control
  import cpacc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic                             regWrSel,
  input  logic                             regWrSecure,
  output regStrobe_t                       strobe,
  input  logic                             reqValid,
  input  logic [CP_W-1:0]                  reqCpNum,
  input  logic [3:0]                       reqClass,
  input  logic                             reqPriv,
  input  logic                             reqNonSecure,
  input  logic [NUM_CP-1:0][FIELD_W-1:0]   fieldQ,
  input  logic [NUM_CP-1:0]                nsMask,
  output logic                             reqPermit,
  output logic                             reqUndef
);
  always_comb begin
    strobe.accWr  = regWrEn && !regWrSel;
    strobe.maskWr = regWrEn && regWrSel && regWrSecure;
  end

  logic [FIELD_W-1:0] selField;
  logic               selMaskBit;
  logic               isGeneral;
  logic               allow;

  always_comb begin
    selField   = ACC_NONE;
    selMaskBit = 1'b0;
    for (int n = 0; n < NUM_CP; n++) begin
      if (reqCpNum == CP_W'(n)) begin
        selField   = fieldQ[n];
        selMaskBit = nsMask[n];
      end
    end
  end

  assign isGeneral = (reqCpNum < CP_W'(NUM_CP));

  always_comb begin
    allow = 1'b0;
    if (isGeneral) begin
      unique case (accField_e'(selField))
        ACC_FULL: allow = 1'b1;
        ACC_PRIV: allow = reqPriv;
        default:  allow = 1'b0;
      endcase
      if (reqNonSecure && !selMaskBit)
        allow = 1'b0;
    end else if (reqCpNum == SYSCTL_CP) begin
      allow = (reqClass == CLS_MOVE_TO) || (reqClass == CLS_MOVE_FROM);
    end
  end

  assign reqPermit = reqValid && allow;
  assign reqUndef  = reqValid && !allow;

  assert_one_answer_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqPermit != reqUndef));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqPermit && !reqUndef));
  assert_unpriv_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqPermit && isGeneral && !reqPriv) |-> (selField == ACC_FULL));
  assert_ns_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isGeneral && reqNonSecure && !selMaskBit) |-> reqUndef);
  assert_sysctl_class_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCpNum == SYSCTL_CP && reqClass > CLS_MOVE_FROM) |-> reqUndef);
  assert_debug_cp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCpNum == DEBUG_CP) |-> reqUndef);
endmodule

// File: rtl/cp_access_unit.sv
module cp_access_unit
  import cpacc_pkg::*;
#(
  parameter logic [NUM_CP-1:0] IMPL_MASK = 14'h0C0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic              regWrSecure,
  input  logic [31:0]       regWrData,
  input  logic              regRdSel,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [3:0]        reqCpNum,
  input  logic [3:0]        reqClass,
  input  logic              reqPriv,
  input  logic              reqNonSecure,
  output logic              reqPermit,
  output logic              reqUndef
);
  regStrobe_t                     strobe;
  logic [NUM_CP-1:0][FIELD_W-1:0] fieldQ;
  logic [NUM_CP-1:0]              nsMask;

  cpacc_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrSel     (regWrSel),
    .regWrSecure  (regWrSecure),
    .strobe       (strobe),
    .reqValid     (reqValid),
    .reqCpNum     (reqCpNum),
    .reqClass     (reqClass),
    .reqPriv      (reqPriv),
    .reqNonSecure (reqNonSecure),
    .fieldQ       (fieldQ),
    .nsMask       (nsMask),
    .reqPermit    (reqPermit),
    .reqUndef     (reqUndef)
  );

  cpacc_datapath #(.IMPL_MASK(IMPL_MASK)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (regWrData),
    .rdSel  (regRdSel),
    .rdData (regRdData),
    .fieldQ (fieldQ),
    .nsMask (nsMask)
  );

  assert_ns_write_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrSel && !regWrSecure) |=> $stable(nsMask));
endmodule

// File: tb/test_cp_access_unit.sv
module test_cp_access_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regWrSel = 1'b0, regWrSecure = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdSel = 1'b0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [3:0]  reqCpNum = '0, reqClass = '0;
  logic        reqPriv = 1'b0, reqNonSecure = 1'b0;
  logic        reqPermit, reqUndef;

  always #2.5 clk = ~clk;

  cp_access_unit i_cp_access_unit (.*);

  typedef struct {
    bit          isReq;
    logic [31:0] expVal;
    string       tag;
  } item_t;

  item_t  sbQ[$];
  event   sampleEv;
  int     nChecks = 0, nFails = 0;
  bit     finished = 0;

  initial forever begin
    @(sampleEv);
    while (sbQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = it.isReq ? {30'd0, reqPermit, reqUndef} : regRdData;
      nChecks++;
      if (act !== it.expVal) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.expVal);
      end
    end
  end

  task automatic doWrite(input logic sel, input logic [31:0] data, input logic sec);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data; regWrSecure = sec;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expRead(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdSel = sel;
    sbQ.push_back('{1'b0, exp, tag});
    #1 -> sampleEv;
  endtask

  // expected encoding: {permit, undef}
  task automatic expReq(input logic [3:0] cp, input logic [3:0] cls, input logic priv,
                        input logic ns, input logic valid, input logic [1:0] exp,
                        input string tag);
    @(negedge clk);
    reqValid = valid; reqCpNum = cp; reqClass = cls; reqPriv = priv; reqNonSecure = ns;
    sbQ.push_back('{1'b1, {30'd0, exp}, tag});
    #1 -> sampleEv;
  endtask

  localparam logic [1:0] PERMIT = 2'b10, UNDEF = 2'b01, IDLE = 2'b00;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expRead(0, 32'h0, "R1 access reg reset");
    expRead(1, 32'h0, "R1 mask reg reset");
    expReq(0, 0, 1, 0, 1, UNDEF, "R1 cp0 after reset");
    expReq(10, 0, 1, 0, 1, UNDEF, "R1 cp10 after reset");
    // R2 probe pattern, R4 reserved bits
    doWrite(0, 32'h0FFF_FFFF, 1);
    expRead(0, 32'h00F0_00FF, "R2 probe readback");
    doWrite(0, 32'hFFFF_FFFF, 1);
    expRead(0, 32'h00F0_00FF, "R4 reserved bits read zero");
    // R11 write lands after the edge
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 1'b0; regWrSecure = 1'b1; regWrData = 32'h0000_0001;
    reqValid = 1; reqCpNum = 0; reqClass = 0; reqPriv = 0; reqNonSecure = 0;
    sbQ.push_back('{1'b1, {30'd0, PERMIT}, "R11 old field before edge"});
    #1 -> sampleEv;
    @(negedge clk);
    regWrEn = 1'b0;
    sbQ.push_back('{1'b1, {30'd0, UNDEF}, "R11 new field after edge"});
    #1 -> sampleEv;
    // R6 field codes: cp0=00 cp1=01 cp2=10 cp3=11
    doWrite(0, 32'h0000_00E4, 1);
    expReq(0, 0, 1, 0, 1, UNDEF,  "R6 code 00 privileged");
    expReq(1, 0, 1, 0, 1, PERMIT, "R6 code 01 privileged");
    expReq(1, 0, 0, 0, 1, UNDEF,  "R6 code 01 unprivileged");
    expReq(2, 0, 1, 0, 1, UNDEF,  "R6 code 10 privileged");
    expReq(3, 0, 0, 0, 1, PERMIT, "R6 code 11 unprivileged");
    // R5 pair tie
    doWrite(0, 32'h00D0_0000, 1);
    expRead(0, 32'h0050_0000, "R5 cp11 follows cp10");
    expReq(11, 0, 0, 0, 1, UNDEF,  "R5 cp11 unprivileged");
    expReq(11, 0, 1, 0, 1, PERMIT, "R5 cp11 privileged");
    doWrite(0, 32'h00C0_0000, 1);
    expRead(0, 32'h0, "R5 cp11 bits alone ignored");
    // R3 unimplemented coprocessor
    doWrite(0, 32'h0000_0C00, 1);
    expRead(0, 32'h0, "R3 cp5 field reads zero");
    expReq(5, 0, 1, 0, 1, UNDEF, "R3 cp5 request");
    // R7 / R8 non-secure mask
    doWrite(0, 32'h0FFF_FFFF, 1);
    expReq(0, 0, 1, 1, 1, UNDEF,  "R7 ns denied by mask");
    expReq(0, 0, 1, 0, 1, PERMIT, "R7 secure ignores mask");
    doWrite(1, 32'h0000_3FFF, 0);
    expRead(1, 32'h0, "R8 ns write dropped");
    expReq(0, 0, 1, 1, 1, UNDEF,  "R8 ns write left mask clear");
    doWrite(1, 32'hFFFF_FFFF, 1);
    expRead(1, 32'h0000_3FFF, "R8 secure write");
    expReq(0, 0, 0, 1, 1, PERMIT, "R7 ns allowed by mask");
    doWrite(1, 32'h0000_3FFE, 1);
    expReq(0, 0, 1, 1, 1, UNDEF,  "R7 ns cp0 bit cleared");
    expReq(1, 0, 1, 1, 1, PERMIT, "R7 ns cp1 bit set");
    // R9 system-control classes
    expReq(15, 0, 0, 1, 1, PERMIT, "R9 class 0");
    expReq(15, 1, 1, 0, 1, PERMIT, "R9 class 1");
    for (int c = 2; c < 16; c++)
      expReq(15, 4'(c), 1, 0, 1, UNDEF, "R9 barred class");
    // R10 coprocessor 14
    expReq(14, 0, 1, 0, 1, UNDEF, "R10 cp14 class 0");
    expReq(14, 1, 1, 0, 1, UNDEF, "R10 cp14 class 1");
    // R12 no request
    expReq(0, 0, 1, 0, 0, IDLE, "R12 idle outputs");
    expReq(15, 0, 1, 0, 0, IDLE, "R12 idle sysctl");
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #100us;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule